// File: doc/BRIEF.md
# Display RAM Address Generator

This block produces the address that drives the display memories. It holds an 11-bit synchronous display counter, built as a cascade of 4-bit stages. A stage moves on only when every stage below it is at its all-ones value and the step strobe is present. All stages update on the same clock edge, so the counter value never passes through intermediate states between edges.

A source selector chooses the memory address. When the select line is low, the processor address is passed through; this path serves acquisition writes. When the select line is high, the counter value is used; this path serves display readout. In envelope mode the counter path inverts its least significant bit. Each stored max/min pair is then read back swapped, so the trace always starts on a minimum point. The lowest stage also exports a flag that is high while its four bits read 15, for use by neighbouring display logic.

The counter advances only on clock edges where the step strobe is high, which stands for "display clocks enabled". A synchronous clear returns it to zero at the start of each display cycle.

Top module: `scan_addr_gen`

## Requirements
- R1: While the active-low reset `rst_n` is low, and on the first edge after it is released with no step, `cnt_val` reads 0 and `lo_max` reads 0.
- R2: On a clock edge with `cnt_step` high and `cnt_clr` low, `cnt_val` increases by exactly one. With both low it holds its value.
- R3: On a clock edge with `cnt_clr` high, `cnt_val` becomes 0 whether or not `cnt_step` is high.
- R4: Bits 10:4 of `cnt_val` change on a stepping edge only when bits 3:0 were 15 before that edge. In that case the upper part increases by one and bits 3:0 become 0.
- R5: `lo_max` is high exactly when bits 3:0 of `cnt_val` equal 15, whether or not a step is requested.
- R6: With `cnt_sel` low, `ram_addr` equals `cpu_addr` in the same cycle, and `env_mode` has no effect on it.
- R7: With `cnt_sel` high and `env_mode` low, `ram_addr` equals `cnt_val`.
- R8: With `cnt_sel` high and `env_mode` high, `ram_addr` equals `cnt_val` with bit 0 inverted and all other bits unchanged.
- R9: A step from 2047 wraps `cnt_val` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous counter clear, has priority over step |
| cnt_step | input | 1 | Count-enable strobe (display clocks enabled) |
| cnt_sel | input | 1 | Address source: 0 processor bus, 1 display counter |
| env_mode | input | 1 | Envelope readout: inverts counter bit 0 on the RAM path |
| cpu_addr | input | 11 | Processor address bus |
| ram_addr | output | 11 | Address applied to the display RAMs |
| cnt_val | output | 11 | Raw display counter value |
| lo_max | output | 1 | Lowest 4-bit stage at count 15 |

## Verification
A corrupted stage register shows up on `cnt_val` at the next edge. It also reaches `ram_addr` in the same cycle whenever the counter path is selected. A broken carry between stages stays hidden until the low nibble passes 15. A fault in the wrap logic appears only on the step out of 2047. For these reasons the counter is walked through its whole range, and the value is compared after every edge. Selector and envelope faults are combinational and appear at once. All four select/mode combinations are therefore applied at every counter value.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;

    localparam int unsigned DEF_CNT_W   = 11;
    localparam int unsigned DEF_STAGE_W = 4;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_CNT = 1'b1
    } addr_src_e;

endpackage

// File: rtl/count_stage.sv
module count_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         carry_in,
    output logic [W-1:0] val,
    output logic         full,
    output logic         carry_out
);

    typedef struct packed {
        logic [W-1:0] val;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    // next-state: clear wins over advance
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = '0;
        end else if (carry_in) begin
            st_d.val = st_q.val + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val       = st_q.val;
    assign full      = &st_q.val;
    assign carry_out = carry_in & full;

endmodule

// File: rtl/addr_mux.sv
module addr_mux
    import scan_addr_pkg::*;
#(
    parameter int unsigned W = 11
) (
    input  logic         sel,
    input  logic         env,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cpu,
    output logic [W-1:0] addr
);

    localparam logic [W-1:0] LSB_MASK = W'(1);

    addr_src_e    src;
    logic [W-1:0] cnt_path;

    always_comb begin
        src      = addr_src_e'(sel);
        cnt_path = env ? (cnt ^ LSB_MASK) : cnt;
        case (src)
            SRC_CNT: addr = cnt_path;
            default: addr = cpu;
        endcase
    end

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_addr_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned STAGE_W = DEF_STAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cnt_step,
    input  logic             cnt_sel,
    input  logic             env_mode,
    input  logic [CNT_W-1:0] cpu_addr,
    output logic [CNT_W-1:0] ram_addr,
    output logic [CNT_W-1:0] cnt_val,
    output logic             lo_max
);

    localparam int unsigned NUM_STG = (CNT_W + STAGE_W - 1) / STAGE_W;
    localparam int unsigned LAST_W  = CNT_W - STAGE_W * (NUM_STG - 1);

    logic [NUM_STG:0]   carry;
    logic [NUM_STG-1:0] full;

    assign carry[0] = cnt_step;

    for (genvar i = 0; i < NUM_STG; i++) begin : g_stage
        localparam int unsigned SW = (i == NUM_STG - 1) ? LAST_W : STAGE_W;
        count_stage #(
            .W (SW)
        ) stage_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (cnt_clr),
            .carry_in  (carry[i]),
            .val       (cnt_val[i*STAGE_W +: SW]),
            .full      (full[i]),
            .carry_out (carry[i+1])
        );
    end

    assign lo_max = full[0];

    addr_mux #(
        .W (CNT_W)
    ) mux_i (
        .sel  (cnt_sel),
        .env  (env_mode),
        .cnt  (cnt_val),
        .cpu  (cpu_addr),
        .addr (ram_addr)
    );

endmodule

// File: rtl/scan_addr_chk.sv
module scan_addr_chk #(
    parameter int unsigned CNT_W   = 11,
    parameter int unsigned STAGE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic             cnt_step,
    input logic             cnt_sel,
    input logic             env_mode,
    input logic [CNT_W-1:0] cpu_addr,
    input logic [CNT_W-1:0] ram_addr,
    input logic [CNT_W-1:0] cnt_val,
    input logic             lo_max,
    input logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_step && !cnt_clr) |=> $stable(cnt_val));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && !cnt_clr) |=> (cnt_val == CNT_W'($past(cnt_val) + ONE)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_val == '0));

    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !lo_max) |=>
            (cnt_val[CNT_W-1:STAGE_W] == $past(cnt_val[CNT_W-1:STAGE_W])));

    p_lo_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_max == (cnt_val[STAGE_W-1:0] == '1));

    p_cpu_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_sel |-> (ram_addr == cpu_addr));

    p_cnt_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && !env_mode) |-> (ram_addr == cnt_val));

    p_env_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && env_mode) |-> (ram_addr == (cnt_val ^ ONE)));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_clr) |=> (cnt_val == '0));

endmodule

bind scan_addr_gen scan_addr_chk #(
    .CNT_W   (CNT_W),
    .STAGE_W (STAGE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_clr  (cnt_clr),
    .cnt_step (cnt_step),
    .cnt_sel  (cnt_sel),
    .env_mode (env_mode),
    .cpu_addr (cpu_addr),
    .ram_addr (ram_addr),
    .cnt_val  (cnt_val),
    .lo_max   (lo_max),
    .wrap     (carry[NUM_STG])
);

// File: tb/scan_addr_gen_tb_top.sv
`timescale 1ns/1ps
module scan_addr_gen_tb_top;

    localparam int CW   = 11;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnt_clr;
    logic          cnt_step;
    logic          cnt_sel;
    logic          env_mode;
    logic [CW-1:0] cpu_addr;
    logic [CW-1:0] ram_addr;
    logic [CW-1:0] cnt_val;
    logic          lo_max;

    int nvec = 0;
    int nerr = 0;
    int expc = 0;

    always #4 clk = ~clk;

    scan_addr_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_step (cnt_step),
        .cnt_sel  (cnt_sel),
        .env_mode (env_mode),
        .cpu_addr (cpu_addr),
        .ram_addr (ram_addr),
        .cnt_val  (cnt_val),
        .lo_max   (lo_max)
    );

    task automatic chk(input string tag, input int got, input int want);
        nvec++;
        if (got != want) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, want);
        end
    endtask

    // counter and flag against the model
    task automatic chk_cnt(input string tag);
        chk(tag, int'(cnt_val), expc);
        chk("R5", int'(lo_max), ((expc % 16) == 15) ? 1 : 0);
    endtask

    // all four select/mode combinations at the current count
    task automatic chk_mux();
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
                cpu_addr = CW'((expc * 7 + s * 341 + e * 1170 + 5) & MAXV);
                cnt_sel  = s[0];
                env_mode = e[0];
                #1;
                if (s == 0)
                    chk("R6", int'(ram_addr), int'(cpu_addr));
                else if (e == 0)
                    chk("R7", int'(ram_addr), expc);
                else
                    chk("R8", int'(ram_addr), expc ^ 1);
            end
        end
    endtask

    task automatic cycle(input logic st, input logic cl);
        string tag;
        cnt_step = st;
        cnt_clr  = cl;
        if (cl)                                tag = "R3";
        else if (st && expc == MAXV)           tag = "R9";
        else if (st && (expc % 16) == 15)      tag = "R4";
        else                                   tag = "R2";
        @(posedge clk);
        #1;
        if (cl)      expc = 0;
        else if (st) expc = (expc + 1) & MAXV;
        cnt_step = 1'b0;
        cnt_clr  = 1'b0;
        chk_cnt(tag);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        cnt_sel  = 1'b0;
        env_mode = 1'b0;
        cpu_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(cnt_val), 0);
        chk("R1", int'(lo_max), 0);
        // stepping is ignored while reset is held
        cnt_step = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", int'(cnt_val), 0);
        cnt_step = 1'b0;
        rst_n    = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", int'(cnt_val), 0);
        chk_mux();

        // hold with no step
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0);

        // full walk, past the wrap, with sparse holds
        for (int n = 0; n < 2060; n++) begin
            if ((n % 97) == 13) cycle(1'b0, 1'b0);
            cycle(1'b1, 1'b0);
            chk_mux();
        end

        // clear alone, then clear with step (priority)
        for (int k = 0; k < 20; k++) cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b1);
        chk_mux();
        for (int k = 0; k < 31; k++) cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        chk_mux();

        // flag held at 15 without stepping
        for (int k = 0; k < 15; k++) cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        chk("R5", int'(lo_max), 1);
        cycle(1'b1, 1'b0);
        chk("R4", int'(cnt_val), 16);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule